// File: doc/BRIEF.md
# Size-Programmable PCI Memory Window Registers

This block holds three 32-bit memory base address registers of a PCI target's configuration header, together with a size-and-prefetch register for each. The size register is a mask. A 1 in a mask bit makes the matching base bit writable. A 0 makes that base bit read as zero and ignore writes. Host software can therefore find each window's size with the usual probe: it writes all ones and reads back which bits stuck. The same registers can be rewritten at run time to resize a window, to change its prefetchable attribute, or to switch the window off.

The block also decodes incoming PCI memory addresses. For an address presented with a request strobe, it reports one cycle later whether a window claims the address, which window it is, and the byte offset of the address inside that window. When windows overlap, the lowest-numbered window is chosen.

Top module: `pci_bar_window`

## Requirements
- R1: After reset, windows 0 and 1 have size mask 0xF800_0000 (128 MiB) and are prefetchable. Window 2 has size mask 0xFF80_0000 (8 MiB) and is not prefetchable. All bases are zero and `dec_hit` is 0. Window 0 and window 1 read as 0x0000_0008, and window 2 reads as 0x0000_0000.
- R2: Windows 0, 1 and 2 sit at configuration dword indices 4, 5 and 6. A read of any other index returns zero, and a write to any other index changes no window.
- R3: In a window read, bit 0 reads as 0 (memory space), bits 2:1 read as 00 (32-bit decode), and bit 3 shows the window's prefetchable attribute.
- R4: A configuration write of 0xFFFF_FFFF with all byte enables set makes the window read back its size mask OR'd with its prefetch bit.
- R5: `cfg_be[k]` enables write data byte k (bits 8k+7:8k). Only bits that are both implemented and byte-enabled take the write data. All other base bits keep their value.
- R6: `size_we[i]` loads `size_wdata` into window i. Bits 31:4 become the size mask, bit 3 becomes the prefetch attribute, and bits 2:0 are ignored. The change is visible on the next cycle. Base bits that the new mask no longer implements are cleared, and they stay cleared if the mask later widens again.
- R7: A window whose size mask is all zero is disabled. It reads as zero, including bit 3, and it never hits.
- R8: When `dec_req` is high at a clock edge, the outputs after that edge are as follows. If some enabled window has `(addr & mask) == (base & mask)`, then `dec_hit` is 1, `dec_bar` holds that window's number, and `dec_off` is `addr & ~mask` (the low 4 bits are always part of the offset). Otherwise all three outputs are 0.
- R9: When more than one window matches, the lowest-numbered window wins.
- R10: A clock edge with `dec_req` low gives `dec_hit` = 0, `dec_bar` = 0 and `dec_off` = 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational on `cfg_idx`) |
| size_we | input | 3 | Per-window size/prefetch write strobes |
| size_wdata | input | 32 | Size mask (31:4) and prefetch bit (3) |
| dec_req | input | 1 | Address decode request |
| dec_addr | input | 32 | PCI memory address to decode |
| dec_hit | output | 1 | Registered: a window claims the address |
| dec_bar | output | 2 | Registered: number of the claiming window |
| dec_off | output | 32 | Registered: byte offset inside the window |

## Verification
A corrupted base or mask bit shows up at the ports in two ways. A configuration read of that window returns the wrong value at once, because the read path is combinational. A decode whose address lies on the wrong side of that bit returns a wrong hit, window number or offset one cycle after the request. The directed scenarios therefore read each window back after every change to it. They also decode addresses placed just inside windows, just outside them and in the overlap between two windows, so that a stuck, lost or leftover bit shows either on the next read or one cycle after the next decode.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;

    localparam int NUM_BAR   = 3;
    localparam int DW        = 32;
    localparam int ATTR_W    = 4;
    localparam int IDX_W     = 6;
    localparam int FIRST_IDX = 4;
    localparam int BE_W      = DW / 8;
    localparam int BAR_IW    = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1;

    typedef logic [DW-1:ATTR_W] base_t;

    typedef struct packed {
        base_t mask;
        logic  pref;
    } win_attr_t;

    typedef struct packed {
        logic              hit;
        logic [BAR_IW-1:0] idx;
        logic [DW-1:0]     off;
    } dec_res_t;

    function automatic int rst_size_log2(input int slot);
        return (slot == 2) ? 23 : 27;
    endfunction

    function automatic logic rst_pref(input int slot);
        return (slot != 2);
    endfunction

    function automatic base_t log2_to_mask(input int lg);
        base_t m;
        for (int b = ATTR_W; b < DW; b++) begin
            m[b] = (b >= lg);
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] be_to_bits(input logic [BE_W-1:0] be);
        logic [DW-1:0] bits;
        for (int k = 0; k < BE_W; k++) begin
            bits[k*8 +: 8] = {8{be[k]}};
        end
        return bits;
    endfunction

endpackage

// File: rtl/pci_bar_slot.sv
module pci_bar_slot
    import pci_bar_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [BE_W-1:0] cfg_be,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            size_wr,
    input  logic [DW-1:0]   size_wdata,
    input  logic [DW-1:0]   addr,
    output logic [DW-1:0]   rd_val,
    output logic            match,
    output base_t           win_mask
);

    localparam base_t RST_MASK = log2_to_mask(rst_size_log2(SLOT));
    localparam logic  RST_PREF = rst_pref(SLOT);

    win_attr_t     attr_q;
    base_t         base_q;
    base_t         wr_mask;
    base_t         base_cfg;
    base_t         base_d;
    logic          enabled;
    logic [DW-1:0] be_bits;
    logic          unused_low;

    assign be_bits    = be_to_bits(cfg_be);
    assign unused_low = ^{be_bits[ATTR_W-1:0], cfg_wdata[ATTR_W-1:0], size_wdata[ATTR_W-2:0]};

    assign wr_mask = attr_q.mask & be_bits[DW-1:ATTR_W];

    always_comb begin
        base_cfg = base_q;
        if (cfg_wr) begin
            base_cfg = (base_q & ~wr_mask) | (cfg_wdata[DW-1:ATTR_W] & wr_mask);
        end
        base_d = base_cfg;
        if (size_wr) begin
            base_d = base_cfg & size_wdata[DW-1:ATTR_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            attr_q.mask <= RST_MASK;
            attr_q.pref <= RST_PREF;
            base_q      <= '0;
        end else begin
            base_q <= base_d;
            if (size_wr) begin
                attr_q.mask <= size_wdata[DW-1:ATTR_W];
                attr_q.pref <= size_wdata[ATTR_W-1];
            end
        end
    end

    assign enabled  = |attr_q.mask;
    assign win_mask = attr_q.mask;
    assign rd_val   = enabled ? {base_q & attr_q.mask, attr_q.pref, {(ATTR_W-1){1'b0}}} : '0;
    assign match    = enabled && (((addr[DW-1:ATTR_W] ^ base_q) & attr_q.mask) == '0);

endmodule

// File: rtl/pci_bar_prio_sel.sv
module pci_bar_prio_sel
    import pci_bar_pkg::*;
(
    input  logic [NUM_BAR-1:0]             match,
    input  logic [NUM_BAR-1:0][DW-1:ATTR_W] masks,
    input  logic [DW-1:0]                  addr,
    output dec_res_t                       res
);

    base_t sel_mask;

    always_comb begin
        res      = '0;
        sel_mask = '0;
        for (int i = NUM_BAR - 1; i >= 0; i--) begin
            if (match[i]) begin
                res.hit  = 1'b1;
                res.idx  = BAR_IW'(i);
                sel_mask = masks[i];
            end
        end
        if (res.hit) begin
            res.off = addr & ~{sel_mask, {ATTR_W{1'b0}}};
        end
    end

endmodule

// File: rtl/pci_bar_window.sv
module pci_bar_window
    import pci_bar_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [BE_W-1:0]     cfg_be,
    input  logic [DW-1:0]       cfg_wdata,
    output logic [DW-1:0]       cfg_rdata,
    input  logic [NUM_BAR-1:0]  size_we,
    input  logic [DW-1:0]       size_wdata,
    input  logic                dec_req,
    input  logic [DW-1:0]       dec_addr,
    output logic                dec_hit,
    output logic [BAR_IW-1:0]   dec_bar,
    output logic [DW-1:0]       dec_off
);

    logic [NUM_BAR-1:0]              slot_match;
    logic [NUM_BAR-1:0][DW-1:ATTR_W] slot_mask;
    logic [NUM_BAR-1:0][DW-1:0]      slot_rd;
    logic [NUM_BAR-1:0]              slot_sel;
    dec_res_t                        sel_res;
    dec_res_t                        res_q;

    for (genvar g = 0; g < NUM_BAR; g++) begin : g_slot
        assign slot_sel[g] = (cfg_idx == IDX_W'(FIRST_IDX + g));

        pci_bar_slot #(.SLOT(g)) slot_i (
            .clk        (clk),
            .rst        (rst),
            .cfg_wr     (cfg_we && slot_sel[g]),
            .cfg_be     (cfg_be),
            .cfg_wdata  (cfg_wdata),
            .size_wr    (size_we[g]),
            .size_wdata (size_wdata),
            .addr       (dec_addr),
            .rd_val     (slot_rd[g]),
            .match      (slot_match[g]),
            .win_mask   (slot_mask[g])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_BAR; i++) begin
            if (slot_sel[i]) begin
                cfg_rdata = slot_rd[i];
            end
        end
    end

    pci_bar_prio_sel prio_i (
        .match (slot_match),
        .masks (slot_mask),
        .addr  (dec_addr),
        .res   (sel_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (dec_req) begin
            res_q <= sel_res;
        end else begin
            res_q <= '0;
        end
    end

    assign dec_hit = res_q.hit;
    assign dec_bar = res_q.idx;
    assign dec_off = res_q.off;

endmodule

// File: rtl/pci_bar_window_chk.sv
module pci_bar_window_chk
    import pci_bar_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               dec_req,
    input logic               dec_hit,
    input logic [BAR_IW-1:0]  dec_bar,
    input logic [DW-1:0]      dec_off,
    input logic [IDX_W-1:0]   cfg_idx,
    input logic [DW-1:0]      cfg_rdata,
    input logic [NUM_BAR-1:0] slot_match
);

    logic idx_in_range;
    assign idx_in_range = (cfg_idx >= IDX_W'(FIRST_IDX)) && (cfg_idx < IDX_W'(FIRST_IDX + NUM_BAR));

    a_r1_reset_no_hit: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dec_hit);

    a_r2_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !idx_in_range |-> cfg_rdata == '0);

    a_r3_type_bits_zero: assert property (@(posedge clk) disable iff (rst)
        idx_in_range |-> cfg_rdata[ATTR_W-2:0] == '0);

    a_r8_match_gives_hit: assert property (@(posedge clk) disable iff (rst)
        (dec_req && (|slot_match)) |=> dec_hit);

    a_r8_no_match_no_hit: assert property (@(posedge clk) disable iff (rst)
        (dec_req && !(|slot_match)) |=> (!dec_hit && dec_off == '0));

    a_r8_index_in_range: assert property (@(posedge clk) disable iff (rst)
        dec_hit |-> dec_bar < BAR_IW'(NUM_BAR));

    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (dec_req && slot_match[0]) |=> (dec_hit && dec_bar == '0));

    a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !dec_req |=> (!dec_hit && dec_bar == '0 && dec_off == '0));

endmodule

bind pci_bar_window pci_bar_window_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .dec_req    (dec_req),
    .dec_hit    (dec_hit),
    .dec_bar    (dec_bar),
    .dec_off    (dec_off),
    .cfg_idx    (cfg_idx),
    .cfg_rdata  (cfg_rdata),
    .slot_match (slot_match)
);

// File: tb/pci_bar_window_tb_top.sv
`timescale 1ns/1ps
module pci_bar_window_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [2:0]  size_we = '0;
    logic [31:0] size_wdata = '0;
    logic        dec_req = 1'b0;
    logic [31:0] dec_addr = '0;
    logic        dec_hit;
    logic [1:0]  dec_bar;
    logic [31:0] dec_off;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pci_bar_window dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .size_we(size_we), .size_wdata(size_wdata),
        .dec_req(dec_req), .dec_addr(dec_addr),
        .dec_hit(dec_hit), .dec_bar(dec_bar), .dec_off(dec_off)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
    endtask

    task automatic size_write(input int slot, input logic [31:0] d);
        @(negedge clk);
        size_we = 3'(1 << slot); size_wdata = d;
        @(negedge clk);
        size_we = '0;
    endtask

    task automatic read_chk(input string req, input logic [5:0] idx, input logic [31:0] exp);
        @(negedge clk);
        cfg_idx = idx;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic dec_chk(input string req, input logic [31:0] a,
                           input logic h, input logic [1:0] b, input logic [31:0] o);
        @(negedge clk);
        dec_req = 1'b1; dec_addr = a;
        @(negedge clk);
        dec_req = 1'b0;
        chk({req, " hit"}, 32'(dec_hit), 32'(h));
        chk({req, " bar"}, 32'(dec_bar), 32'(b));
        chk({req, " off"}, dec_off, o);
    endtask

    task automatic t_reset;
        chk("R1 hit after reset", 32'(dec_hit), 32'h0);
        read_chk("R1 bar0 reset", 6'd4, 32'h0000_0008);
        read_chk("R1 bar1 reset", 6'd5, 32'h0000_0008);
        read_chk("R1 bar2 reset", 6'd6, 32'h0000_0000);
    endtask

    task automatic t_probe;
        cfg_write(6'd4, 32'hFFFF_FFFF, 4'hF);
        cfg_write(6'd5, 32'hFFFF_FFFF, 4'hF);
        cfg_write(6'd6, 32'hFFFF_FFFF, 4'hF);
        read_chk("R4 R3 probe bar0", 6'd4, 32'hF800_0008);
        read_chk("R4 R3 probe bar1", 6'd5, 32'hF800_0008);
        read_chk("R4 R3 probe bar2", 6'd6, 32'hFF80_0000);
        cfg_write(6'd4, 32'h0, 4'hF);
        cfg_write(6'd5, 32'h0, 4'hF);
        cfg_write(6'd6, 32'h0, 4'hF);
        read_chk("R4 clear bar1", 6'd5, 32'h0000_0008);
    endtask

    task automatic t_byte_en;
        cfg_write(6'd4, 32'hFFFF_FFFF, 4'b0111);
        read_chk("R5 low bytes only", 6'd4, 32'h0000_0008);
        cfg_write(6'd4, 32'hFFFF_FFFF, 4'b1000);
        read_chk("R5 top byte", 6'd4, 32'hF800_0008);
        cfg_write(6'd4, 32'h0800_0000, 4'hF);
        read_chk("R5 base set", 6'd4, 32'h0800_0008);
    endtask

    task automatic t_other_idx;
        cfg_write(6'd3, 32'hFFFF_FFFF, 4'hF);
        cfg_write(6'd7, 32'hFFFF_FFFF, 4'hF);
        read_chk("R2 idx3 zero", 6'd3, 32'h0);
        read_chk("R2 idx7 zero", 6'd7, 32'h0);
        read_chk("R2 bar0 untouched", 6'd4, 32'h0800_0008);
        read_chk("R2 bar1 untouched", 6'd5, 32'h0000_0008);
        read_chk("R2 bar2 untouched", 6'd6, 32'h0000_0000);
    endtask

    task automatic t_decode;
        cfg_write(6'd6, 32'h4080_0000, 4'hF);
        read_chk("R8 bar2 base", 6'd6, 32'h4080_0000);
        dec_chk("R8 bar2 hit", 32'h4080_1234, 1'b1, 2'd2, 32'h0000_1234);
        dec_chk("R8 bar0 hit", 32'h0812_3456, 1'b1, 2'd0, 32'h0012_3456);
        dec_chk("R8 miss", 32'h1000_0000, 1'b0, 2'd0, 32'h0);
        dec_chk("R8 bar2 just below", 32'h407F_FFFC, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_resize;
        size_write(2, 32'hFF00_0000);
        read_chk("R6 shrink clears bit", 6'd6, 32'h4000_0000);
        size_write(2, 32'hFF80_0000);
        read_chk("R6 cleared stays", 6'd6, 32'h4000_0000);
        size_write(2, 32'hFF80_000F);
        read_chk("R6 R3 prefetch on", 6'd6, 32'h4000_0008);
        dec_chk("R6 resized decode", 32'h4000_0040, 1'b1, 2'd2, 32'h0000_0040);
    endtask

    task automatic t_priority;
        size_write(1, 32'hF000_0008);
        read_chk("R9 bar1 resized", 6'd5, 32'h0000_0008);
        dec_chk("R9 overlap lowest", 32'h0800_1234, 1'b1, 2'd0, 32'h0000_1234);
        dec_chk("R9 bar1 only", 32'h0000_0010, 1'b1, 2'd1, 32'h0000_0010);
    endtask

    task automatic t_idle;
        dec_chk("R10 setup", 32'h0000_0010, 1'b1, 2'd1, 32'h0000_0010);
        @(negedge clk);
        chk("R10 idle hit", 32'(dec_hit), 32'h0);
        chk("R10 idle off", dec_off, 32'h0);
    endtask

    task automatic t_disable;
        size_write(2, 32'h0000_0000);
        read_chk("R7 disabled reads zero", 6'd6, 32'h0);
        cfg_write(6'd6, 32'hFFFF_FFFF, 4'hF);
        read_chk("R7 disabled ignores write", 6'd6, 32'h0);
        dec_chk("R7 disabled no hit", 32'h4000_0040, 1'b0, 2'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_probe();
        t_byte_en();
        t_other_idx();
        t_decode();
        t_resize();
        t_priority();
        t_idle();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule